// File: doc/BRIEF.md
# Serial Batch Transaction Controller

This block runs a complete request/response exchange between a host on an asynchronous serial line and a wide user processing core. It gathers a fixed number of bytes from the line into one parallel operand. Then it starts the core with a single pulse and holds in a processing phase until the core reports completion. Finally it returns the core's parallel result to the host as a series of byte frames.

The block contains a byte-level serial receiver and a byte-level serial transmitter, both with simple valid/ready byte ports. It also has a two-stage synchronizer on the incoming line and a sequencer that handles the multi-byte work. The total operand and result width is a single parameter, `TOTAL_BITS`. No other part needs editing when that width changes. The core only sees `core_start_o`, `core_operand_o`, `core_done_i` and `core_result_i`.

Top module: `serial_batch_ctrl`

## Requirements
- R1: Both serial directions use frames of one low start bit, eight data bits least significant bit first, and one high stop bit, each bit lasting `CLKS_PER_BIT` clocks. The line idles high, and the incoming line passes through a two-flop synchronizer.
- R2: The block collects `TOTAL_BITS/8` bytes. The first byte received lands in operand bits 7:0, and byte k lands in bits 8k+7:8k.
- R3: When the last input byte arrives, `core_start_o` is high for exactly one cycle, one pulse per transaction. `core_operand_o` holds the assembled word during that pulse and stays stable throughout processing.
- R4: The block waits in the processing phase for `core_done_i`, however long that takes, and sends nothing on `tx_o` while it waits.
- R5: The result is captured in the cycle where `core_done_i` is high. Later changes on `core_result_i` do not alter the bytes sent.
- R6: The result is sent least significant byte first, with exactly one frame per byte. A byte is handed to the transmitter only when the transmitter is ready.
- R7: Bytes that complete while the block is processing or sending are discarded and never enter the next operand.
- R8: After the last result byte is accepted, the block returns to collecting with its byte counter at zero. The next transaction therefore starts again at bits 7:0.
- R9: While `rst_ni` is low, `tx_o` is high, `core_start_o` is low and the block is in the collecting phase with a zero byte count.
- R10: A `core_done_i` pulse during the collecting phase has no effect: no start, no capture and no transmission.
- R11: An incoming frame whose stop bit reads low is dropped and does not count as a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line from host (asynchronous) |
| tx_o | output | 1 | Serial line to host |
| core_start_o | output | 1 | One-cycle start pulse to the core |
| core_operand_o | output | TOTAL_BITS | Assembled operand for the core |
| core_done_i | input | 1 | Core completion flag |
| core_result_i | input | TOTAL_BITS | Core result, sampled when done is high |

## Verification
Two functions can meet in one cycle. A host byte can finish on the receive side while the sequencer is busy processing or while it is handing a result byte to the transmitter. The bench sends stray bytes during long processing windows and sends another stray byte fully overlapped with the reply's transmission. It judges the outcome by the reply bytes popped from the scoreboard and by the operand the core model sees at the next start pulse. Both must match values built only from the bytes the host meant to send.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_KICK    = 2'd1,
    ST_WAIT    = 2'd2,
    ST_EMIT    = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sbc_sync2.sv
module sbc_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RESET_VAL;
      sync_q <= RESET_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sbc_byte_rx.sv
module sbc_byte_rx
  import sbc_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int CW   = $clog2(CLKS_PER_BIT);
  localparam int HALF = CLKS_PER_BIT / 2 - 1;
  localparam int FULL = CLKS_PER_BIT - 1;

  rx_state_e     st_q;
  logic [CW-1:0] tick_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RX_IDLE;
      tick_q <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      case (st_q)
        RX_IDLE: begin
          tick_q <= '0;
          if (!line_i) st_q <= RX_START;
        end
        RX_START: begin
          if (tick_q == CW'(HALF)) begin
            tick_q <= '0;
            bit_q  <= '0;
            // glitch rejection: start must still be low mid-bit
            st_q   <= line_i ? RX_IDLE : RX_DATA;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (tick_q == CW'(FULL)) begin
            tick_q <= '0;
            sh_q   <= {line_i, sh_q[7:1]};
            bit_q  <= bit_q + 1'b1;
            if (bit_q == 3'd7) st_q <= RX_STOP;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (tick_q == CW'(FULL)) begin
            tick_q <= '0;
            vld_q  <= line_i;  // framing error drops the byte
            st_q   <= RX_IDLE;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  assign valid_o = vld_q;
  assign data_o  = sh_q;
endmodule

// File: rtl/sbc_byte_tx.sv
module sbc_byte_tx #(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [7:0] data_i,
  output logic       ready_o,
  output logic       line_o
);
  localparam int CW    = $clog2(CLKS_PER_BIT);
  localparam int FULL  = CLKS_PER_BIT - 1;
  localparam int NBITS = 10;

  logic          busy_q;
  logic [CW-1:0] tick_q;
  logic [3:0]    bit_q;
  logic [9:0]    sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      bit_q  <= '0;
      sh_q   <= '1;
    end else if (!busy_q) begin
      if (valid_i) begin
        busy_q <= 1'b1;
        tick_q <= '0;
        bit_q  <= '0;
        sh_q   <= {1'b1, data_i, 1'b0};
      end
    end else if (tick_q == CW'(FULL)) begin
      tick_q <= '0;
      sh_q   <= {1'b1, sh_q[9:1]};
      if (bit_q == 4'(NBITS - 1)) busy_q <= 1'b0;
      else bit_q <= bit_q + 1'b1;
    end else begin
      tick_q <= tick_q + 1'b1;
    end
  end

  assign ready_o = !busy_q;
  assign line_o  = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/sbc_sequencer.sv
module sbc_sequencer
  import sbc_pkg::*;
#(
  parameter int TOTAL_BITS = 32,
  localparam int NBYTES = TOTAL_BITS / 8,
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rx_valid_i,
  input  logic [7:0]            rx_data_i,
  output logic                  tx_valid_o,
  output logic [7:0]            tx_data_o,
  input  logic                  tx_ready_i,
  output logic                  start_o,
  output logic [TOTAL_BITS-1:0] operand_o,
  input  logic                  done_i,
  input  logic [TOTAL_BITS-1:0] result_i,
  output seq_state_e            state_o,
  output logic [CNT_W-1:0]      cnt_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  if (TOTAL_BITS % 8 != 0 || TOTAL_BITS < 8) begin : g_bad_width
    $error("TOTAL_BITS must be a positive multiple of 8");
  end

  seq_state_e            st_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [TOTAL_BITS-1:0] in_q, out_q;
  logic                  take, fire;

  assign take = (st_q == ST_COLLECT) && rx_valid_i;
  assign fire = (st_q == ST_EMIT) && tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_COLLECT;
      cnt_q <= '0;
    end else begin
      case (st_q)
        ST_COLLECT: if (take) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_KICK;
        end
        ST_KICK: st_q <= ST_WAIT;
        ST_WAIT: if (done_i) st_q <= ST_EMIT;
        ST_EMIT: if (fire) begin
          cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == LAST) st_q <= ST_COLLECT;
        end
        default: st_q <= ST_COLLECT;
      endcase
    end
  end

  // per-byte input lanes
  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) in_q[g*8 +: 8] <= '0;
      else if (take && cnt_q == CNT_W'(g)) in_q[g*8 +: 8] <= rx_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else if (st_q == ST_WAIT && done_i) out_q <= result_i;
  end

  assign tx_valid_o = fire;
  assign tx_data_o  = out_q[cnt_q*8 +: 8];
  assign start_o    = (st_q == ST_KICK);
  assign operand_o  = in_q;
  assign state_o    = st_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/serial_batch_ctrl.sv
module serial_batch_ctrl
  import sbc_pkg::*;
#(
  parameter int TOTAL_BITS   = 32,
  parameter int CLKS_PER_BIT = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rx_i,
  output logic                  tx_o,
  output logic                  core_start_o,
  output logic [TOTAL_BITS-1:0] core_operand_o,
  input  logic                  core_done_i,
  input  logic [TOTAL_BITS-1:0] core_result_i
);
  localparam int NBYTES = TOTAL_BITS / 8;
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic             rx_s;
  logic             rx_vld, tx_vld, tx_rdy;
  logic [7:0]       rx_byte, tx_byte;
  seq_state_e       seq_state;
  logic [CNT_W-1:0] seq_cnt;

  sbc_sync2 #(.RESET_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s)
  );

  sbc_byte_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk_i, .rst_ni, .line_i(rx_s), .valid_o(rx_vld), .data_o(rx_byte)
  );

  sbc_byte_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk_i, .rst_ni, .valid_i(tx_vld), .data_i(tx_byte),
    .ready_o(tx_rdy), .line_o(tx_o)
  );

  sbc_sequencer #(.TOTAL_BITS(TOTAL_BITS)) u_seq (
    .clk_i, .rst_ni,
    .rx_valid_i(rx_vld), .rx_data_i(rx_byte),
    .tx_valid_o(tx_vld), .tx_data_o(tx_byte), .tx_ready_i(tx_rdy),
    .start_o(core_start_o), .operand_o(core_operand_o),
    .done_i(core_done_i), .result_i(core_result_i),
    .state_o(seq_state), .cnt_o(seq_cnt)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
  import sbc_pkg::*;
#(
  parameter int TOTAL_BITS = 32,
  localparam int NBYTES = TOTAL_BITS / 8,
  localparam int CNT_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic [TOTAL_BITS-1:0] operand_i,
  input logic                  done_i,
  input seq_state_e            state_i,
  input logic [CNT_W-1:0]      cnt_i,
  input logic                  tx_vld_i,
  input logic                  tx_rdy_i,
  input logic                  rx_vld_i
);
  p_start_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !start_i);

  p_operand_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT) |=> $stable(operand_i));

  p_done_leaves_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && done_i) |=> (state_i == ST_EMIT));

  p_hold_without_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_WAIT && !done_i) |=> (state_i == ST_WAIT));

  p_tx_accepts_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_vld_i |=> !tx_rdy_i);

  p_no_emit_elsewhere_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_EMIT) |-> !tx_vld_i);

  p_stray_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_vld_i && state_i == ST_WAIT) |=> $stable(operand_i));

  p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_EMIT && tx_vld_i && cnt_i == CNT_W'(NBYTES - 1))
      |=> (state_i == ST_COLLECT && cnt_i == '0));

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_COLLECT && !rx_vld_i) |=> (state_i == ST_COLLECT && !start_i));
endmodule

bind serial_batch_ctrl sbc_checker #(.TOTAL_BITS(TOTAL_BITS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (core_start_o),
  .operand_i (core_operand_o),
  .done_i    (core_done_i),
  .state_i   (seq_state),
  .cnt_i     (seq_cnt),
  .tx_vld_i  (tx_vld),
  .tx_rdy_i  (tx_rdy),
  .rx_vld_i  (rx_vld)
);

// File: tb/serial_batch_ctrl_tb.sv
module serial_batch_ctrl_tb;
  localparam int TB_BITS = 32;
  localparam int NB      = TB_BITS / 8;
  localparam int CPB     = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               rx = 1'b1;
  logic               tx;
  logic               start;
  logic [TB_BITS-1:0] operand;
  logic               model_done = 1'b0, glitch_done = 1'b0;
  logic [TB_BITS-1:0] result = '0;

  int checks = 0, fails = 0, starts = 0;
  int proc_delay = 20;
  logic [TB_BITS-1:0] exp_operand = '0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  serial_batch_ctrl #(.TOTAL_BITS(TB_BITS), .CLKS_PER_BIT(CPB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tx_o(tx),
    .core_start_o(start), .core_operand_o(operand),
    .core_done_i(model_done | glitch_done), .core_result_i(result)
  );

  function automatic logic [TB_BITS-1:0] core_fn(logic [TB_BITS-1:0] a);
    return {a[TB_BITS-6:0], a[TB_BITS-1:TB_BITS-5]} ^ 32'hA5C3_1E7F;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_bit);
    @(negedge clk); rx = 1'b0;
    repeat (CPB) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i];
      repeat (CPB) @(negedge clk);
    end
    rx = stop_bit;
    repeat (CPB) @(negedge clk);
    rx = 1'b1;
    repeat (CPB) @(negedge clk);
  endtask

  // core model: checks operand at start, holds, pulses done, then scrambles result
  initial begin
    forever begin
      @(negedge clk);
      if (start) begin
        starts++;
        chk(operand == exp_operand, "R2/R3 operand at start", 64'(operand), 64'(exp_operand));
        @(negedge clk);
        chk(!start, "R3 start width", 64'(start), 64'd0);
        for (int i = 0; i < proc_delay; i++) begin
          chk(tx == 1'b1 && operand == exp_operand, "R4 quiet while processing", 64'(tx), 64'd1);
          @(negedge clk);
        end
        model_done = 1'b1;
        result = core_fn(exp_operand);
        @(negedge clk);
        model_done = 1'b0;
        result = ~result;  // R5: must not reach the line
      end
    end
  end

  // monitor: decode serial output, compare against scoreboard
  initial begin
    logic [7:0] b;
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (rst_n && tx == 1'b0) begin
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
          repeat (CPB) @(negedge clk);
          b[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        chk(tx == 1'b1, "R1 stop bit", 64'(tx), 64'd1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7/R10 unexpected byte", 64'(b), 64'hFF);
        end else begin
          e = exp_q.pop_front();
          chk(b == e, "R5/R6 result byte", 64'(b), 64'(e));
        end
      end
    end
  end

  // mode: 0 plain, 1 done glitch mid-collect, 2 bad frame first,
  //       3 stray during processing, 4 stray during reply
  task automatic run_txn(input logic [TB_BITS-1:0] w, input int dly, input int mode);
    int s0;
    logic [TB_BITS-1:0] r;
    s0 = starts;
    exp_operand = w;
    proc_delay = dly;
    r = core_fn(w);
    for (int i = 0; i < NB; i++) exp_q.push_back(r[i*8 +: 8]);
    if (mode == 2) send_frame(8'h3C, 1'b0);   // R11
    for (int i = 0; i < NB; i++) begin
      send_frame(w[i*8 +: 8], 1'b1);
      if (mode == 1 && i == 1) begin
        @(negedge clk); glitch_done = 1'b1;
        @(negedge clk); glitch_done = 1'b0;
        chk(starts == s0, "R10 done glitch ignored", 64'(starts), 64'(s0));
      end
    end
    if (mode == 3) send_frame(8'hE7, 1'b1);   // R7
    if (mode == 4) begin
      while (tx !== 1'b0) @(negedge clk);
      send_frame(8'h81, 1'b1);                 // R7, overlaps reply
    end
    for (int t = 0; t < 4000 && exp_q.size() != 0; t++) @(negedge clk);
    repeat (12 * CPB) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all bytes sent", 64'(exp_q.size()), 64'd0);
    chk(starts == s0 + 1, "R3 one start per txn", 64'(starts), 64'(s0 + 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R9 tx idle in reset", 64'(tx), 64'd1);
    chk(start == 1'b0, "R9 no start in reset", 64'(start), 64'd0);
    chk(operand == '0, "R9 operand cleared", 64'(operand), 64'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx == 1'b1 && start == 1'b0, "R9 idle after reset", 64'(tx), 64'd1);

    run_txn(32'h4433_2211, 20, 0);   // R2 byte order
    run_txn(32'hDEAD_BEEF, 3, 0);    // R8 restart from byte 0
    run_txn(32'h0000_00FF, 1, 1);    // R10
    run_txn(32'h8001_7FFE, 15, 2);   // R11
    run_txn(32'h1234_5678, 120, 3);  // R7 during processing
    run_txn(32'hCAFE_F00D, 5, 4);    // R7 during reply
    run_txn(32'h0F0F_A5A5, 200, 0);  // R4 long wait
    run_txn(32'hFFFF_FFFF, 0, 0);    // R5 immediate done
    finish_run();
  end
endmodule